// File: doc/BRIEF.md
# Token-Balanced Compute Core Partitioner

This block splits a pool of compute cores among the kernels that are currently active. Each kernel sits in a status slot and holds a signed token count. A core that a kernel gains costs it one token, and a core taken away from it returns one. Each core has a status entry with four fields: its owning slot, its state (Idle, Running or Reserved), a running thread-block count and the slot that is next in line for it.

Inserting a kernel, or removing a finished one, starts a rebalancing pass. The pass makes one move per clock cycle. Idle cores go first, one at a time, to the kernel with the most tokens. Once no core is idle, a Running core of the kernel with the fewest tokens is marked Reserved for the kernel with the most tokens. A Reserved core drains: when its thread-block count reaches zero it changes hands. Issuing the thread blocks is done elsewhere. This block only sees block start and finish pulses for each core, and it publishes the core table and the token counts.

Top module: `token_core_partitioner`

## Requirements
- R1: After reset every core is Idle (state code 0) with owner 0, next 0 and count 0. Every slot is invalid with token 0, done_o is 1, ins_ready_o is 1 and ins_slot_o is 0. State codes are 0 Idle, 1 Running and 2 Reserved.
- R2: An insert loads the lowest-index invalid slot, shown on ins_slot_o, with the zero-extended ins_tok_i and marks the slot valid. When all slots are valid, ins_ready_o is 0 and an insert changes no slot.
- R3: An accepted insert or removal drives done_o to 0 on the following cycle. While done_o is 1 and no insert or removal arrives, done_o stays 1 and the tables do not change.
- R4: A pass makes at most one assignment or reservation per cycle, and none in a cycle that carries an insert or a removal.
- R5: If a core is Idle, the lowest-index Idle core becomes Running with count 0. It goes to the valid slot with the highest token count, ties going to the lowest slot index, and that slot's token drops by 1.
- R6: If no core is Idle, and the highest token count minus the lowest is at least 2, and the lowest-count slot (ties to the lowest index) owns a Running core, then its lowest-index Running core becomes Reserved with next set to the highest-count slot. The lowest-count slot's token rises by 1 and the highest-count slot's token drops by 1.
- R7: The pass ends, with done_o back at 1, when no move under R5 or R6 is possible. This covers a gap of less than 2 and a lowest-count slot that owns no Running core.
- R8: For a Running or Reserved core, tb_start_i adds 1 to its count and tb_done_i subtracts 1, saturating at 0. An Idle core ignores both and keeps count 0.
- R9: A Reserved core whose count is 0 becomes Running, owned by its next slot, on the next clock edge.
- R10: A removal of a valid slot does four things. The slot becomes invalid with token 0. Its Running cores become Idle with count 0. Its Reserved cores become Running, owned by their next slot, with count 0. Reservations made for the removed slot are cancelled: those cores return to Running under their owner, keeping their count, and the owner's token drops by 1 for each one.
- R11: The token count of a valid slot never falls below minus the number of cores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ins_valid_i | input | 1 | Insert a kernel |
| ins_tok_i | input | TOK_W-1 | Initial token count of the inserted kernel |
| ins_ready_o | output | 1 | A free slot exists |
| ins_slot_o | output | SLOT_W | Slot the next insert will take |
| rem_valid_i | input | 1 | Remove a finished kernel |
| rem_slot_i | input | SLOT_W | Slot to remove |
| tb_start_i | input | NUM_CORES | Per-core thread-block start pulse |
| tb_done_i | input | NUM_CORES | Per-core thread-block finish pulse |
| core_state_o | output | NUM_CORES x 2 | Core state codes |
| core_owner_o | output | NUM_CORES x SLOT_W | Owning slot for each core |
| core_next_o | output | NUM_CORES x SLOT_W | Next slot for each core |
| core_cnt_o | output | NUM_CORES x CNT_W | Running block count for each core |
| slot_valid_o | output | NUM_SLOTS | Slot valid bits |
| slot_tok_o | output | NUM_SLOTS x TOK_W | Signed token count for each slot |
| done_o | output | 1 | No rebalancing pass in progress |

## Verification
A wrong token update shows up in slot_tok_o on the edge that makes the move. The error also steers the following moves to the wrong core or slot, so core_owner_o or core_next_o differ within a few cycles. Walking the pass one cycle at a time exposes a bad choice of victim or tie-break on the very edge it is made. A broken stop test either leaves done_o low, which the bounded wait reports, or swaps cores back and forth, which shows as wrong final owners. Drain and cancel faults appear on the edge after the block count reaches zero or the removal lands, as a wrong state or owner on that core.

// File: rtl/tcp_pkg.sv
package tcp_pkg;
  typedef enum logic [1:0] {
    CORE_IDLE = 2'd0,
    CORE_RUN  = 2'd1,
    CORE_RSV  = 2'd2
  } core_state_e;
endpackage

// File: rtl/tcp_pick.sv
module tcp_pick #(
  parameter int N  = 4,
  parameter int W  = 8,
  parameter int IW = 2
) (
  input  logic [N-1:0]        valid_i,
  input  logic [N-1:0][W-1:0] val_i,
  output logic                any_o,
  output logic [IW-1:0]       max_idx_o,
  output logic [IW-1:0]       min_idx_o,
  output logic signed [W-1:0] max_val_o,
  output logic signed [W-1:0] min_val_o
);
  // strict compares keep the lowest index on ties
  always_comb begin
    any_o     = 1'b0;
    max_idx_o = '0;
    min_idx_o = '0;
    max_val_o = '0;
    min_val_o = '0;
    for (int i = 0; i < N; i++) begin
      if (valid_i[i]) begin
        if (!any_o || $signed(val_i[i]) > max_val_o) begin
          max_val_o = $signed(val_i[i]);
          max_idx_o = IW'(i);
        end
        if (!any_o || $signed(val_i[i]) < min_val_o) begin
          min_val_o = $signed(val_i[i]);
          min_idx_o = IW'(i);
        end
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tcp_slot_table.sv
module tcp_slot_table #(
  parameter int NUM_SLOTS = 4,
  parameter int NUM_CORES = 4,
  parameter int TOK_W     = 8,
  parameter int SLOT_W    = 2,
  parameter int CCW       = 3
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            ins_fire_i,
  input  logic [TOK_W-2:0]                ins_tok_i,
  input  logic                            rem_fire_i,
  input  logic [SLOT_W-1:0]               rem_slot_i,
  input  logic                            dec_en_i,
  input  logic [SLOT_W-1:0]               dec_slot_i,
  input  logic                            inc_en_i,
  input  logic [SLOT_W-1:0]               inc_slot_i,
  input  logic [NUM_SLOTS-1:0][CCW-1:0]   cancel_i,
  output logic [NUM_SLOTS-1:0]            valid_o,
  output logic [NUM_SLOTS-1:0][TOK_W-1:0] tok_o,
  output logic                            free_o,
  output logic [SLOT_W-1:0]               free_idx_o
);
  localparam int TokFloor = -NUM_CORES;

  logic [NUM_SLOTS-1:0]            valid_q;
  logic [NUM_SLOTS-1:0][TOK_W-1:0] tok_q;

  always_comb begin
    free_o     = 1'b0;
    free_idx_o = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (!valid_q[i] && !free_o) begin
        free_o     = 1'b1;
        free_idx_o = SLOT_W'(i);
      end
    end
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [TOK_W-1:0] tok_d;
    logic [TOK_W-1:0] inc_v, dec_v;

    assign inc_v = (inc_en_i && inc_slot_i == SLOT_W'(s)) ? TOK_W'(1) : '0;
    assign dec_v = (dec_en_i && dec_slot_i == SLOT_W'(s)) ? TOK_W'(1) : '0;
    assign tok_d = tok_q[s] + inc_v - dec_v - TOK_W'(cancel_i[s]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[s] <= 1'b0;
        tok_q[s]   <= '0;
      end else if (ins_fire_i && free_idx_o == SLOT_W'(s)) begin
        valid_q[s] <= 1'b1;
        tok_q[s]   <= TOK_W'(ins_tok_i);
      end else if (rem_fire_i && rem_slot_i == SLOT_W'(s)) begin
        valid_q[s] <= 1'b0;
        tok_q[s]   <= '0;
      end else begin
        tok_q[s]   <= tok_d;
      end
    end

    // R11
    tok_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_q[s] |-> ($signed(tok_q[s]) >= TokFloor));

    // R10
    inv_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_q[s] |-> (tok_q[s] == '0));
  end

  // R2
  ins_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_fire_i |=> valid_q[$past(free_idx_o)]);

  assign valid_o = valid_q;
  assign tok_o   = tok_q;
endmodule

// File: rtl/tcp_core_table.sv
module tcp_core_table
  import tcp_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_SLOTS = 4,
  parameter int SLOT_W    = 2,
  parameter int CORE_W    = 2,
  parameter int CNT_W     = 4,
  parameter int CCW       = 3
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_CORES-1:0]             tb_start_i,
  input  logic [NUM_CORES-1:0]             tb_done_i,
  input  logic                             rem_fire_i,
  input  logic [SLOT_W-1:0]                rem_slot_i,
  input  logic                             asg_en_i,
  input  logic [CORE_W-1:0]                asg_core_i,
  input  logic [SLOT_W-1:0]                asg_slot_i,
  input  logic                             rsv_en_i,
  input  logic [CORE_W-1:0]                rsv_core_i,
  input  logic [SLOT_W-1:0]                rsv_slot_i,
  input  logic [SLOT_W-1:0]                victim_slot_i,
  output logic [NUM_CORES-1:0][1:0]        state_o,
  output logic [NUM_CORES-1:0][SLOT_W-1:0] owner_o,
  output logic [NUM_CORES-1:0][SLOT_W-1:0] next_o,
  output logic [NUM_CORES-1:0][CNT_W-1:0]  cnt_o,
  output logic                             any_idle_o,
  output logic [CORE_W-1:0]                idle_idx_o,
  output logic                             has_victim_o,
  output logic [CORE_W-1:0]                victim_idx_o,
  output logic [NUM_SLOTS-1:0][CCW-1:0]    cancel_o
);
  localparam logic [CNT_W-1:0] CntMax = '1;

  core_state_e             state_q [NUM_CORES];
  logic [SLOT_W-1:0]       owner_q [NUM_CORES];
  logic [SLOT_W-1:0]       next_q  [NUM_CORES];
  logic [CNT_W-1:0]        cnt_q   [NUM_CORES];
  logic [NUM_CORES-1:0]    idle_vec, rsv_vec;

  always_comb begin
    any_idle_o   = 1'b0;
    idle_idx_o   = '0;
    has_victim_o = 1'b0;
    victim_idx_o = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (state_q[c] == CORE_IDLE && !any_idle_o) begin
        any_idle_o = 1'b1;
        idle_idx_o = CORE_W'(c);
      end
      if (state_q[c] == CORE_RUN && owner_q[c] == victim_slot_i && !has_victim_o) begin
        has_victim_o = 1'b1;
        victim_idx_o = CORE_W'(c);
      end
    end
  end

  // per-owner count of reservations cancelled by a removal
  always_comb begin
    for (int s = 0; s < NUM_SLOTS; s++) begin
      cancel_o[s] = '0;
      for (int c = 0; c < NUM_CORES; c++) begin
        if (rem_fire_i && state_q[c] == CORE_RSV && next_q[c] == rem_slot_i &&
            owner_q[c] != rem_slot_i && owner_q[c] == SLOT_W'(s))
          cancel_o[s] = cancel_o[s] + CCW'(1);
      end
    end
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
      cnt_d = cnt_q[c];
      if (state_q[c] != CORE_IDLE) begin
        if (tb_start_i[c] && !tb_done_i[c] && cnt_q[c] != CntMax)
          cnt_d = cnt_q[c] + CNT_W'(1);
        else if (tb_done_i[c] && !tb_start_i[c] && cnt_q[c] != '0)
          cnt_d = cnt_q[c] - CNT_W'(1);
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        state_q[c] <= CORE_IDLE;
        owner_q[c] <= '0;
        next_q[c]  <= '0;
        cnt_q[c]   <= '0;
      end else if (rem_fire_i && state_q[c] == CORE_RUN && owner_q[c] == rem_slot_i) begin
        state_q[c] <= CORE_IDLE;
        cnt_q[c]   <= '0;
      end else if (rem_fire_i && state_q[c] == CORE_RSV && owner_q[c] == rem_slot_i) begin
        state_q[c] <= CORE_RUN;
        owner_q[c] <= next_q[c];
        cnt_q[c]   <= '0;
      end else if (rem_fire_i && state_q[c] == CORE_RSV && next_q[c] == rem_slot_i) begin
        state_q[c] <= CORE_RUN;
        cnt_q[c]   <= cnt_d;
      end else if (asg_en_i && asg_core_i == CORE_W'(c)) begin
        state_q[c] <= CORE_RUN;
        owner_q[c] <= asg_slot_i;
        cnt_q[c]   <= '0;
      end else if (rsv_en_i && rsv_core_i == CORE_W'(c)) begin
        state_q[c] <= CORE_RSV;
        next_q[c]  <= rsv_slot_i;
        cnt_q[c]   <= cnt_d;
      end else if (state_q[c] == CORE_RSV && cnt_q[c] == '0) begin
        // drained: hand over to the reserving kernel
        state_q[c] <= CORE_RUN;
        owner_q[c] <= next_q[c];
        cnt_q[c]   <= cnt_d;
      end else begin
        cnt_q[c]   <= cnt_d;
      end
    end

    assign state_o[c]  = state_q[c];
    assign owner_o[c]  = owner_q[c];
    assign next_o[c]   = next_q[c];
    assign cnt_o[c]    = cnt_q[c];
    assign idle_vec[c] = (state_q[c] == CORE_IDLE);
    assign rsv_vec[c]  = (state_q[c] == CORE_RSV);

    // R1
    legal_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      state_q[c] != 2'd3);

    // R6
    rsv_next_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q[c] == CORE_RSV) |-> (next_q[c] != owner_q[c]));

    // R9
    drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q[c] == CORE_RSV && cnt_q[c] == '0 && !rem_fire_i)
        |=> (state_q[c] == CORE_RUN && owner_q[c] == $past(next_q[c])));

    // R8
    idle_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q[c] == CORE_IDLE) |-> (cnt_q[c] == '0));
  end

  // R4
  one_asg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones($past(idle_vec) & ~idle_vec) <= 1);

  // R4
  one_rsv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(rsv_vec & ~$past(rsv_vec)) <= 1);
endmodule

// File: rtl/token_core_partitioner.sv
module token_core_partitioner #(
  parameter int NUM_CORES = 4,
  parameter int NUM_SLOTS = 4,
  parameter int TOK_W     = 8,
  parameter int CNT_W     = 4,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             ins_valid_i,
  input  logic [TOK_W-2:0]                 ins_tok_i,
  output logic                             ins_ready_o,
  output logic [SLOT_W-1:0]                ins_slot_o,
  input  logic                             rem_valid_i,
  input  logic [SLOT_W-1:0]                rem_slot_i,
  input  logic [NUM_CORES-1:0]             tb_start_i,
  input  logic [NUM_CORES-1:0]             tb_done_i,
  output logic [NUM_CORES-1:0][1:0]        core_state_o,
  output logic [NUM_CORES-1:0][SLOT_W-1:0] core_owner_o,
  output logic [NUM_CORES-1:0][SLOT_W-1:0] core_next_o,
  output logic [NUM_CORES-1:0][CNT_W-1:0]  core_cnt_o,
  output logic [NUM_SLOTS-1:0]             slot_valid_o,
  output logic [NUM_SLOTS-1:0][TOK_W-1:0]  slot_tok_o,
  output logic                             done_o
);
  localparam int CCW = $clog2(NUM_CORES + 1);

  logic                          ins_fire, rem_fire;
  logic                          any_valid, any_idle, has_victim;
  logic [SLOT_W-1:0]             max_slot, min_slot;
  logic signed [TOK_W-1:0]       max_tok, min_tok;
  logic signed [TOK_W:0]         gap;
  logic [CORE_W-1:0]             idle_idx, victim_idx;
  logic [NUM_SLOTS-1:0][CCW-1:0] cancel;
  logic                          step_ok, do_assign, do_reserve;
  logic                          busy_q;

  assign ins_fire = ins_valid_i & ins_ready_o;
  assign rem_fire = rem_valid_i & slot_valid_o[rem_slot_i];

  tcp_pick #(
    .N  (NUM_SLOTS),
    .W  (TOK_W),
    .IW (SLOT_W)
  ) i_pick (
    .valid_i   (slot_valid_o),
    .val_i     (slot_tok_o),
    .any_o     (any_valid),
    .max_idx_o (max_slot),
    .min_idx_o (min_slot),
    .max_val_o (max_tok),
    .min_val_o (min_tok)
  );

  assign gap        = {max_tok[TOK_W-1], max_tok} - {min_tok[TOK_W-1], min_tok};
  assign step_ok    = busy_q & ~ins_fire & ~rem_fire & any_valid;
  assign do_assign  = step_ok & any_idle;
  // a gap of one would only swap the two kernels forever
  assign do_reserve = step_ok & ~any_idle & has_victim & (gap >= 2);

  tcp_slot_table #(
    .NUM_SLOTS (NUM_SLOTS),
    .NUM_CORES (NUM_CORES),
    .TOK_W     (TOK_W),
    .SLOT_W    (SLOT_W),
    .CCW       (CCW)
  ) i_slots (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ins_fire_i (ins_fire),
    .ins_tok_i  (ins_tok_i),
    .rem_fire_i (rem_fire),
    .rem_slot_i (rem_slot_i),
    .dec_en_i   (do_assign | do_reserve),
    .dec_slot_i (max_slot),
    .inc_en_i   (do_reserve),
    .inc_slot_i (min_slot),
    .cancel_i   (cancel),
    .valid_o    (slot_valid_o),
    .tok_o      (slot_tok_o),
    .free_o     (ins_ready_o),
    .free_idx_o (ins_slot_o)
  );

  tcp_core_table #(
    .NUM_CORES (NUM_CORES),
    .NUM_SLOTS (NUM_SLOTS),
    .SLOT_W    (SLOT_W),
    .CORE_W    (CORE_W),
    .CNT_W     (CNT_W),
    .CCW       (CCW)
  ) i_cores (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tb_start_i    (tb_start_i),
    .tb_done_i     (tb_done_i),
    .rem_fire_i    (rem_fire),
    .rem_slot_i    (rem_slot_i),
    .asg_en_i      (do_assign),
    .asg_core_i    (idle_idx),
    .asg_slot_i    (max_slot),
    .rsv_en_i      (do_reserve),
    .rsv_core_i    (victim_idx),
    .rsv_slot_i    (max_slot),
    .victim_slot_i (min_slot),
    .state_o       (core_state_o),
    .owner_o       (core_owner_o),
    .next_o        (core_next_o),
    .cnt_o         (core_cnt_o),
    .any_idle_o    (any_idle),
    .idle_idx_o    (idle_idx),
    .has_victim_o  (has_victim),
    .victim_idx_o  (victim_idx),
    .cancel_o      (cancel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   busy_q <= 1'b0;
    else if (ins_fire || rem_fire)                 busy_q <= 1'b1;
    else if (busy_q && !do_assign && !do_reserve)  busy_q <= 1'b0;
  end

  assign done_o = ~busy_q;

  // R3
  trig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_fire || rem_fire) |=> !done_o);

  // R3
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !ins_fire && !rem_fire) |=> done_o);

  // R7
  stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_o && !ins_fire && !rem_fire && !any_idle && (gap < 2)) |=> done_o);
endmodule

// File: tb/test_token_core_partitioner.sv
module test_token_core_partitioner;
  localparam int NC = 4;
  localparam int NS = 4;
  localparam int TW = 8;
  localparam int CW = 4;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              ins_valid = 1'b0;
  logic [TW-2:0]     ins_tok = '0;
  logic              ins_ready;
  logic [1:0]        ins_slot;
  logic              rem_valid = 1'b0;
  logic [1:0]        rem_slot = '0;
  logic [NC-1:0]     tb_start = '0;
  logic [NC-1:0]     tb_done = '0;
  logic [NC-1:0][1:0]    st;
  logic [NC-1:0][1:0]    own;
  logic [NC-1:0][1:0]    nxt;
  logic [NC-1:0][CW-1:0] cnt;
  logic [NS-1:0]         vld;
  logic [NS-1:0][TW-1:0] tok;
  logic                  done;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  token_core_partitioner #(.NUM_CORES(NC), .NUM_SLOTS(NS), .TOK_W(TW), .CNT_W(CW))
  i_token_core_partitioner (
    .clk_i(clk), .rst_ni(rst_ni),
    .ins_valid_i(ins_valid), .ins_tok_i(ins_tok),
    .ins_ready_o(ins_ready), .ins_slot_o(ins_slot),
    .rem_valid_i(rem_valid), .rem_slot_i(rem_slot),
    .tb_start_i(tb_start), .tb_done_i(tb_done),
    .core_state_o(st), .core_owner_o(own), .core_next_o(nxt), .core_cnt_o(cnt),
    .slot_valid_o(vld), .slot_tok_o(tok), .done_o(done)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_core(input string req, input int c, input int s, input int o);
    chk(req, $sformatf("core%0d state", c), int'(st[c]), s);
    chk(req, $sformatf("core%0d owner", c), int'(own[c]), o);
  endtask

  function automatic int tk(input int s);
    return int'($signed(tok[s]));
  endfunction

  task automatic do_insert(input int t);
    @(negedge clk); ins_valid = 1'b1; ins_tok = (TW-1)'(t);
    @(negedge clk); ins_valid = 1'b0;
  endtask

  task automatic do_remove(input int s);
    @(negedge clk); rem_valid = 1'b1; rem_slot = 2'(s);
    @(negedge clk); rem_valid = 1'b0;
  endtask

  task automatic pulse(input logic [NC-1:0] sm, input logic [NC-1:0] dm);
    @(negedge clk); tb_start = sm; tb_done = dm;
    @(negedge clk); tb_start = '0; tb_done = '0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 100) begin @(negedge clk); n++; end
    chk(req, "pass finished", int'(done), 1);
  endtask

  task automatic t_reset;
    for (int c = 0; c < NC; c++) begin
      chk_core("R1", c, 0, 0);
      chk("R1", "next", int'(nxt[c]), 0);
      chk("R1", "cnt", int'(cnt[c]), 0);
    end
    chk("R1", "valid", int'(vld), 0);
    chk("R1", "tok0", tk(0), 0);
    chk("R1", "done", int'(done), 1);
    chk("R1", "ins_ready", int'(ins_ready), 1);
    chk("R1", "ins_slot", int'(ins_slot), 0);
    pulse(4'b0001, 4'b0000);
    chk("R8", "idle core ignores start", int'(cnt[0]), 0);
  endtask

  task automatic t_fill;
    do_insert(2);
    chk("R2", "slot0 valid", int'(vld[0]), 1);
    chk("R2", "slot0 tok", tk(0), 2);
    chk("R3", "done low after insert", int'(done), 0);
    @(negedge clk);
    chk_core("R5", 0, 1, 0);
    chk_core("R4", 1, 0, 0);
    chk("R5", "tok0 after one step", tk(0), 1);
    wait_done("R7");
    for (int c = 0; c < NC; c++) chk_core("R5", c, 1, 0);
    chk("R11", "tok0 floor", tk(0), -2);
    pulse(4'b1111, 4'b0000);
    pulse(4'b1111, 4'b0000);
    for (int c = 0; c < NC; c++) chk("R8", "count after starts", int'(cnt[c]), 2);
  endtask

  task automatic t_reserve;
    chk("R2", "next slot", int'(ins_slot), 1);
    do_insert(2);
    @(negedge clk);
    chk_core("R6", 0, 2, 0);
    chk("R6", "core0 next", int'(nxt[0]), 1);
    chk_core("R4", 1, 1, 0);
    chk("R6", "tok0 step1", tk(0), -1);
    chk("R6", "tok1 step1", tk(1), 1);
    wait_done("R7");
    chk_core("R6", 1, 2, 0);
    chk("R6", "core1 next", int'(nxt[1]), 1);
    chk_core("R7", 2, 1, 0);
    chk_core("R7", 3, 1, 0);
    chk("R7", "tok0 balanced", tk(0), 0);
    chk("R7", "tok1 balanced", tk(1), 0);
    pulse(4'b0000, 4'b0001);
    chk("R8", "core0 cnt dec", int'(cnt[0]), 1);
    chk_core("R9", 0, 2, 0);
    pulse(4'b0000, 4'b0001);
    chk("R8", "core0 cnt zero", int'(cnt[0]), 0);
    @(negedge clk);
    chk_core("R9", 0, 1, 1);
  endtask

  task automatic t_ties;
    do_insert(0);
    chk("R3", "done low after insert", int'(done), 0);
    wait_done("R7");
    chk("R7", "tok2 unchanged", tk(2), 0);
    chk_core("R7", 0, 1, 1);
    chk_core("R7", 1, 2, 0);
    do_insert(3);
    wait_done("R7");
    @(negedge clk); @(negedge clk);
    chk_core("R9", 0, 1, 3);
    chk_core("R6", 1, 2, 0);
    chk("R6", "core1 next", int'(nxt[1]), 1);
    chk_core("R6", 2, 2, 0);
    chk("R6", "core2 next", int'(nxt[2]), 3);
    chk_core("R6", 3, 1, 0);
    chk("R6", "tok0", tk(0), 1);
    chk("R6", "tok1", tk(1), 1);
    chk("R6", "tok2", tk(2), 0);
    chk("R6", "tok3", tk(3), 1);
    chk("R2", "full ready", int'(ins_ready), 0);
    @(negedge clk);
    chk("R3", "idle hold done", int'(done), 1);
    chk("R3", "idle hold tok3", tk(3), 1);
  endtask

  task automatic t_remove;
    do_remove(0);
    chk("R10", "slot0 valid", int'(vld[0]), 0);
    chk("R10", "slot0 tok", tk(0), 0);
    chk_core("R10", 3, 0, 0);
    chk("R10", "core3 cnt", int'(cnt[3]), 0);
    chk_core("R10", 1, 1, 1);
    chk("R10", "core1 cnt", int'(cnt[1]), 0);
    chk_core("R10", 2, 1, 3);
    chk("R3", "done low after remove", int'(done), 0);
    wait_done("R7");
    chk_core("R5", 3, 1, 1);
    chk("R5", "tok1", tk(1), 0);
    chk("R5", "tok3", tk(3), 1);
    chk("R2", "ready again", int'(ins_ready), 1);
    chk("R2", "free slot", int'(ins_slot), 0);
  endtask

  task automatic t_cancel;
    pulse(4'b1111, 4'b0000);
    do_insert(3);
    wait_done("R7");
    chk_core("R6", 1, 2, 1);
    chk("R6", "core1 next", int'(nxt[1]), 0);
    chk_core("R7", 0, 1, 3);
    chk("R7", "tok0", tk(0), 2);
    chk("R7", "tok1", tk(1), 1);
    chk("R7", "tok2 no cores", tk(2), 0);
    do_remove(0);
    chk_core("R10", 1, 1, 1);
    chk("R10", "core1 cnt kept", int'(cnt[1]), 1);
    chk("R10", "tok1 cancelled", tk(1), 0);
    wait_done("R7");
    chk("R7", "tok3", tk(3), 1);
  endtask

  task automatic t_full;
    do_insert(0);
    wait_done("R7");
    chk("R2", "all valid", int'(vld), 15);
    chk("R2", "not ready", int'(ins_ready), 0);
    do_insert(5);
    chk("R2", "ignored tok0", tk(0), 0);
    chk("R2", "ignored valid", int'(vld), 15);
    chk("R3", "no trigger", int'(done), 1);
    pulse(4'b0000, 4'b1000);
    pulse(4'b0000, 4'b1000);
    chk("R8", "saturate at zero", int'(cnt[3]), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_reserve();
    t_ties();
    t_remove();
    t_cancel();
    t_full();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule